// File: doc/BRIEF.md
# Power Controller Fault and Status Register Bank

This block holds two six-bit registers for a hot-plug power controller. The status register mirrors which abnormal conditions exist right now. The fault register latches which conditions have occurred since they were last cleared. The conditions are overvoltage, undervoltage, overcurrent, power-bad and FET-short. A sixth bit tracks the plug-in card: the status register shows whether a board is present, and the fault register records that the enable input changed state. The sequencer provides per-condition present levels and filtered fault events. It reads the latched faults back, together with a single hold-off flag that tells it whether the switch must stay off.

Several clear sources act on the fault register, and each one reaches a different set of bits:
- A bus write clears chosen bits, but it cannot clear a bit whose condition is still shown as present.
- A board insertion clears the four electrical fault bits.
- Turning the switch off, a qualified undervoltage-reset level, or internal supply lockout wipes the whole register.

Two small state machines do the sequencing. The board tracker has the states `BRD_UNSEEN`, `BRD_ABSENT` and `BRD_PRESENT`:
- `BRD_UNSEEN` → `BRD_ABSENT` or `BRD_PRESENT`: the first sample after reset. No change is logged.
- `BRD_ABSENT` → `BRD_PRESENT`: insertion, when enable goes low.
- `BRD_PRESENT` → `BRD_ABSENT`: removal, when enable goes high.

The undervoltage-reset qualifier has the states `UVQ_IDLE`, `UVQ_WAIT` and `UVQ_HOLD`:
- `UVQ_IDLE` → `UVQ_WAIT`: the level is first seen high.
- `UVQ_WAIT` → `UVQ_HOLD`: the level has been high for `UVR_QUAL_CYC` consecutive samples.
- `UVQ_WAIT` → `UVQ_IDLE` and `UVQ_HOLD` → `UVQ_IDLE`: the level is sampled low.

Top module: `pwr_fault_bank`

## Requirements
- R1: Status bits use this positional encoding: bit 0 overvoltage, bit 1 undervoltage, bit 2 overcurrent, bit 3 power-bad, bit 4 board-present, bit 5 FET-short. Bits 0–3 and 5 show the matching level input as sampled at the previous clock edge. All outputs are zero during reset.
- R2: Fault bits use the same positions, except that bit 4 is the enable change-of-state flag. Fault bits 0–2 are set by `ov_evt`, `uv_evt` and `oc_evt`. Fault bits 3 and 5 are set while `pbad_lvl` and `fshort_lvl` are high. A set fault bit stays set after its condition goes away.
- R3: The first clock edge after reset only samples `en_pin`. Low gives board-present status 1, high gives 0. Fault bit 4 is not set.
- R4: When `en_pin` is low while the board is absent (insertion), fault bit 4 is set, fault bits 0–3 are cleared, board-present status is set and fault bit 5 is kept.
- R5: When `en_pin` is high while the board is present (removal), fault bit 4 is set, board-present status clears and the other fault bits are kept.
- R6: A bus write (`wr_en`) with a 0 in bit k clears fault bit k, unless k is not 4 and status bit k is currently 1. Fault bit 4 can always be cleared.
- R7: A bus write with a 1 in bits 0–2 sets those fault bits. A 1 in bits 3–5 has no effect.
- R8: A falling edge of `on_pin` or of `fet_on` clears the whole fault register.
- R9: Once `uv_rst_lvl` has been high for `UVR_QUAL_CYC` consecutive samples, the whole fault register clears on every following edge, up to and including the edge where the level is first sampled low. A shorter high run has no effect.
- R10: While `uvlo` is high, the whole fault register clears on every edge.
- R11: When a set source and any clear source hit the same fault bit on the same edge, the bit ends up set.
- R12: `hold_off` is high when, for any k in 0–2, either `retry_en[k]` is 0 and fault bit k is 1, or `retry_en[k]` is 1 and status bit k is 1.
- R13: Changing `retry_en` never changes the fault register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_lvl | input | 1 | Overvoltage present |
| uv_lvl | input | 1 | Undervoltage present |
| oc_lvl | input | 1 | Overcurrent present |
| pbad_lvl | input | 1 | Qualified power-bad present |
| fshort_lvl | input | 1 | Qualified FET-short present |
| ov_evt | input | 1 | Overvoltage fault event |
| uv_evt | input | 1 | Undervoltage fault event |
| oc_evt | input | 1 | Overcurrent fault event |
| en_pin | input | 1 | Board enable, low means inserted |
| on_pin | input | 1 | On-request level |
| fet_on | input | 1 | FET-on control bit level |
| uv_rst_lvl | input | 1 | Undervoltage below reset level |
| uvlo | input | 1 | Internal supply lockout |
| wr_en | input | 1 | Bus write strobe for the fault register |
| wr_data | input | 6 | Bus write data |
| retry_en | input | 3 | Auto-retry enables for OV, UV, OC |
| sts_q | output | 6 | Status register |
| flt_q | output | 6 | Latched fault register |
| hold_off | output | 1 | Switch must stay off |

## Verification
The hardest case to reach from the ports is the undervoltage-reset qualifier at its boundary. A high run one sample short must leave the faults untouched. A run of exactly `UVR_QUAL_CYC` samples must not clear yet, and the clear must land on the edge after that. The bench holds `uv_rst_lvl` for counted runs of both lengths while a latched fault is present. It then fires a fault event during the hold, so that set-over-clear priority is also seen under the qualifier. Coincident lockout and event stimulus, an insertion with a FET-short fault pending, and a long pseudo-random phase are all compared every clock against a behavioural model.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    localparam int NB    = 6;
    localparam int NR    = 3;
    localparam int B_OV  = 0;
    localparam int B_UV  = 1;
    localparam int B_OC  = 2;
    localparam int B_PB  = 3;
    localparam int B_BRD = 4;
    localparam int B_FS  = 5;

    typedef logic [NB-1:0] pfb_vec_t;

    typedef enum logic [1:0] {
        BRD_UNSEEN,
        BRD_ABSENT,
        BRD_PRESENT
    } brd_state_t;

    typedef enum logic [1:0] {
        UVQ_IDLE,
        UVQ_WAIT,
        UVQ_HOLD
    } uvq_state_t;

endpackage

// File: rtl/pfb_board_fsm.sv
module pfb_board_fsm
    import pfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    output logic ins_evt,
    output logic rem_evt,
    output logic present
);

    brd_state_t state_q;
    brd_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BRD_UNSEEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BRD_UNSEEN:  state_d = en_pin ? BRD_ABSENT : BRD_PRESENT;
            BRD_ABSENT:  if (!en_pin) state_d = BRD_PRESENT;
            BRD_PRESENT: if (en_pin)  state_d = BRD_ABSENT;
            default:     state_d = BRD_UNSEEN;
        endcase
    end

    // Edge pulses are valid in the cycle before the state register moves.
    always_comb begin
        ins_evt = 1'b0;
        rem_evt = 1'b0;
        present = 1'b0;
        unique case (state_q)
            BRD_UNSEEN:  ;
            BRD_ABSENT:  ins_evt = !en_pin;
            BRD_PRESENT: begin
                present = 1'b1;
                rem_evt = en_pin;
            end
            default:     ;
        endcase
    end

endmodule

// File: rtl/pfb_uvr_qual.sv
module pfb_uvr_qual
    import pfb_pkg::*;
#(
    parameter int QUAL_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic clr
);

    localparam int CW = (QUAL_CYC < 2) ? 1 : $clog2(QUAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

    uvq_state_t state_q;
    uvq_state_t state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UVQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // cnt_q holds the number of consecutive high samples seen so far.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            UVQ_IDLE: begin
                if (lvl) begin
                    if (QUAL_CYC <= 1) begin
                        state_d = UVQ_HOLD;
                    end else begin
                        state_d = UVQ_WAIT;
                        cnt_d   = CW'(1);
                    end
                end
            end
            UVQ_WAIT: begin
                if (!lvl) begin
                    state_d = UVQ_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = UVQ_HOLD;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            UVQ_HOLD: begin
                if (!lvl) begin
                    state_d = UVQ_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = UVQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        clr = 1'b0;
        unique case (state_q)
            UVQ_HOLD: clr = 1'b1;
            default:  clr = 1'b0;
        endcase
    end

endmodule

// File: rtl/pfb_latch_bit.sv
module pfb_latch_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    // Set dominates clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end else if (clr_i) begin
            q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwr_fault_bank.sv
module pwr_fault_bank
    import pfb_pkg::*;
#(
    parameter int UVR_QUAL_CYC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ov_lvl,
    input  logic          uv_lvl,
    input  logic          oc_lvl,
    input  logic          pbad_lvl,
    input  logic          fshort_lvl,
    input  logic          ov_evt,
    input  logic          uv_evt,
    input  logic          oc_evt,
    input  logic          en_pin,
    input  logic          on_pin,
    input  logic          fet_on,
    input  logic          uv_rst_lvl,
    input  logic          uvlo,
    input  logic          wr_en,
    input  logic [NB-1:0] wr_data,
    input  logic [NR-1:0] retry_en,
    output logic [NB-1:0] sts_q,
    output logic [NB-1:0] flt_q,
    output logic          hold_off
);

    logic     ins_evt;
    logic     rem_evt;
    logic     brd_present;
    logic     uvr_clr;
    logic     on_prev_q;
    logic     fet_prev_q;
    logic     wipe_all;
    pfb_vec_t lvl_vec;
    pfb_vec_t set_vec;
    pfb_vec_t clr_vec;

    pfb_board_fsm u_board (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_pin  (en_pin),
        .ins_evt (ins_evt),
        .rem_evt (rem_evt),
        .present (brd_present)
    );

    pfb_uvr_qual #(
        .QUAL_CYC (UVR_QUAL_CYC)
    ) u_uvq (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (uv_rst_lvl),
        .clr   (uvr_clr)
    );

    always_comb begin
        lvl_vec        = '0;
        lvl_vec[B_OV]  = ov_lvl;
        lvl_vec[B_UV]  = uv_lvl;
        lvl_vec[B_OC]  = oc_lvl;
        lvl_vec[B_PB]  = pbad_lvl;
        lvl_vec[B_FS]  = fshort_lvl;
    end

    // The condition bits follow their levels. Bit 4 is taken from the board tracker state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q      <= '0;
            on_prev_q  <= 1'b0;
            fet_prev_q <= 1'b0;
        end else begin
            sts_q        <= lvl_vec;
            sts_q[B_BRD] <= (ins_evt | brd_present) & ~rem_evt | (~brd_present & ~rem_evt & ~en_pin);
            on_prev_q    <= on_pin;
            fet_prev_q   <= fet_on;
        end
    end

    assign wipe_all = uvlo | uvr_clr | (on_prev_q & ~on_pin) | (fet_prev_q & ~fet_on);

    always_comb begin
        set_vec        = '0;
        set_vec[B_OV]  = ov_evt | (wr_en & wr_data[B_OV]);
        set_vec[B_UV]  = uv_evt | (wr_en & wr_data[B_UV]);
        set_vec[B_OC]  = oc_evt | (wr_en & wr_data[B_OC]);
        set_vec[B_PB]  = pbad_lvl;
        set_vec[B_BRD] = ins_evt | rem_evt;
        set_vec[B_FS]  = fshort_lvl;
        for (int i = 0; i < NB; i++) begin
            clr_vec[i] = wipe_all
                       | (ins_evt & (i < B_BRD))
                       | (wr_en & ~wr_data[i] & ((i == B_BRD) ? 1'b1 : ~sts_q[i]));
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_cell
        pfb_latch_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[g]),
            .clr_i (clr_vec[g]),
            .q     (flt_q[g])
        );
    end

    always_comb begin
        hold_off = 1'b0;
        for (int k = 0; k < NR; k++) begin
            hold_off = hold_off | (retry_en[k] ? sts_q[k] : flt_q[k]);
        end
    end

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker
    import pfb_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          ov_lvl,
    input logic          ov_evt,
    input logic          uvlo,
    input logic          wr_en,
    input logic [NB-1:0] wr_data,
    input logic [NR-1:0] retry_en,
    input logic [NB-1:0] sts_q,
    input logic [NB-1:0] flt_q,
    input logic          hold_off
);

    // R1
    ov_status_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sts_q[B_OV] == $past(ov_lvl));

    // R2
    ov_event_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_evt |=> flt_q[B_OV]);

    // R5
    removal_logs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_q[B_BRD]) |-> flt_q[B_BRD]);

    // R10
    lockout_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo && !ov_evt && !(wr_en && wr_data[B_OV])) |=> !flt_q[B_OV]);

    // R11
    set_beats_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo && ov_evt) |=> flt_q[B_OV]);

    // R12
    latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!retry_en[B_OV] && flt_q[B_OV]) |-> hold_off);

    // R12
    present_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_en[B_UV] && sts_q[B_UV]) |-> hold_off);

endmodule

bind pwr_fault_bank pfb_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ov_lvl   (ov_lvl),
    .ov_evt   (ov_evt),
    .uvlo     (uvlo),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .retry_en (retry_en),
    .sts_q    (sts_q),
    .flt_q    (flt_q),
    .hold_off (hold_off)
);

// File: tb/pwr_fault_bank_test.sv
module pwr_fault_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int QUAL       = 5;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ov_lvl = 0, uv_lvl = 0, oc_lvl = 0, pbad_lvl = 0, fshort_lvl = 0;
    logic       ov_evt = 0, uv_evt = 0, oc_evt = 0;
    logic       en_pin = 0, on_pin = 0, fet_on = 0, uv_rst_lvl = 0, uvlo = 0;
    logic       wr_en = 0;
    logic [5:0] wr_data = '0;
    logic [2:0] retry_en = '0;
    logic [5:0] sts_q, flt_q;
    logic       hold_off;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_on = 0;
    string cur_req = "R1";

    logic [5:0] m_sts = '0, m_flt = '0, nf;
    int         brd = 0, run = 0;
    bit         p_on = 0, p_fet = 0, ins, rem, wipe, kill, mk;
    logic [15:0] lfsr = 16'hACE1;

    pwr_fault_bank #(.UVR_QUAL_CYC(QUAL)) uut (
        .clk(clk), .rst_n(rst_n),
        .ov_lvl(ov_lvl), .uv_lvl(uv_lvl), .oc_lvl(oc_lvl),
        .pbad_lvl(pbad_lvl), .fshort_lvl(fshort_lvl),
        .ov_evt(ov_evt), .uv_evt(uv_evt), .oc_evt(oc_evt),
        .en_pin(en_pin), .on_pin(on_pin), .fet_on(fet_on),
        .uv_rst_lvl(uv_rst_lvl), .uvlo(uvlo),
        .wr_en(wr_en), .wr_data(wr_data), .retry_en(retry_en),
        .sts_q(sts_q), .flt_q(flt_q), .hold_off(hold_off)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string tag, string what, logic [5:0] got, logic [5:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    function automatic logic model_hold();
        logic h = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (retry_en[k] && m_sts[k]) h = 1'b1;
            if (!retry_en[k] && m_flt[k]) h = 1'b1;
        end
        return h;
    endfunction

    // Behavioural reference: one update per rising edge, from inputs and its own state.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sts = '0; m_flt = '0; brd = 0; run = 0; p_on = 0; p_fet = 0;
        end else begin
            ins  = (brd == 1) && !en_pin;
            rem  = (brd == 2) && en_pin;
            wipe = uvlo || (run >= QUAL) || (p_on && !on_pin) || (p_fet && !fet_on);
            for (int b = 0; b < 6; b++) begin
                kill = wipe || (ins && b <= 3) ||
                       (wr_en && !wr_data[b] && (b == 4 || !m_sts[b]));
                case (b)
                    0: mk = ov_evt || (wr_en && wr_data[0]);
                    1: mk = uv_evt || (wr_en && wr_data[1]);
                    2: mk = oc_evt || (wr_en && wr_data[2]);
                    3: mk = pbad_lvl;
                    4: mk = ins || rem;
                    default: mk = fshort_lvl;
                endcase
                nf[b] = mk ? 1'b1 : (kill ? 1'b0 : m_flt[b]);
            end
            m_flt = nf;
            if (brd == 0) brd = en_pin ? 1 : 2;
            else if (ins) brd = 2;
            else if (rem) brd = 1;
            m_sts = {fshort_lvl, (brd == 2), pbad_lvl, oc_lvl, uv_lvl, ov_lvl};
            run   = uv_rst_lvl ? ((run < 1000) ? run + 1 : run) : 0;
            p_on  = on_pin;
            p_fet = fet_on;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cur_req, "model sts", sts_q, m_sts);
            chk(cur_req, "model flt", flt_q, m_flt);
            chk(cur_req, "model hold", {5'b0, hold_off}, {5'b0, model_hold()});
        end
    end

    task automatic pulse_ov();
        ov_evt = 1; cyc(); ov_evt = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        cmp_on = 1;
        // R1 reset state
        chk("R1", "reset sts", sts_q, 6'b000000);
        chk("R1", "reset flt", flt_q, 6'b000000);
        chk("R1", "reset hold", {5'b0, hold_off}, 6'b0);
        rst_n = 1;
        cyc();
        cur_req = "R3";
        chk("R3", "first sample sts", sts_q, 6'b010000);
        chk("R3", "first sample flt", flt_q, 6'b000000);

        cur_req = "R1";
        ov_lvl = 1; pbad_lvl = 1; cyc();
        chk("R1", "levels sts", sts_q, 6'b011001);
        chk("R2", "pbad latch", flt_q, 6'b001000);
        ov_lvl = 0; pbad_lvl = 0; cyc();
        chk("R1", "levels gone sts", sts_q, 6'b010000);
        chk("R2", "pbad held", flt_q, 6'b001000);

        cur_req = "R2";
        ov_evt = 1; oc_evt = 1; cyc(); ov_evt = 0; oc_evt = 0;
        chk("R2", "events", flt_q, 6'b001101);
        fshort_lvl = 1; cyc(); fshort_lvl = 0;
        chk("R2", "fshort sts", sts_q, 6'b110000);
        chk("R2", "fshort flt", flt_q, 6'b101101);
        cyc();
        chk("R2", "fshort held", flt_q, 6'b101101);

        cur_req = "R6";
        uv_lvl = 1; uv_evt = 1; cyc(); uv_evt = 0;
        chk("R6", "uv latched", flt_q, 6'b101111);
        wr_en = 1; wr_data = 6'b000000; cyc(); wr_en = 0;
        chk("R6", "protected uv", flt_q, 6'b000010);
        uv_lvl = 0; cyc();
        wr_en = 1; cyc(); wr_en = 0;
        chk("R6", "uv cleared", flt_q, 6'b000000);

        cur_req = "R7";
        wr_en = 1; wr_data = 6'b111111; cyc(); wr_en = 0;
        chk("R7", "write ones", flt_q, 6'b000111);
        chk("R7", "sts untouched", sts_q, 6'b010000);

        cur_req = "R12";
        retry_en = 3'b000; #1;
        chk("R12", "latched hold", {5'b0, hold_off}, 6'b1);
        retry_en = 3'b111; #1;
        chk("R12", "retry no present", {5'b0, hold_off}, 6'b0);
        ov_lvl = 1; cyc();
        chk("R12", "retry present", {5'b0, hold_off}, 6'b1);
        ov_lvl = 0; cyc();
        chk("R12", "retry gone", {5'b0, hold_off}, 6'b0);

        cur_req = "R13";
        retry_en = 3'b000; cyc();
        chk("R13", "retry 000", flt_q, 6'b000111);
        retry_en = 3'b101; cyc();
        chk("R13", "retry 101", flt_q, 6'b000111);
        retry_en = 3'b010; cyc();
        chk("R13", "retry 010", flt_q, 6'b000111);
        retry_en = 3'b000;

        cur_req = "R5";
        en_pin = 1; cyc();
        chk("R5", "removal sts", sts_q, 6'b000000);
        chk("R5", "removal flt", flt_q, 6'b010111);

        cur_req = "R4";
        fshort_lvl = 1; pbad_lvl = 1; cyc(); fshort_lvl = 0; pbad_lvl = 0; cyc();
        chk("R4", "before insert", flt_q, 6'b111111);
        en_pin = 0; cyc();
        chk("R4", "insert flt", flt_q, 6'b110000);
        chk("R4", "insert sts", sts_q, 6'b010000);

        cur_req = "R6";
        wr_en = 1; wr_data = 6'b100000; cyc(); wr_en = 0;
        chk("R6", "bit4 clearable", flt_q, 6'b100000);

        cur_req = "R8";
        on_pin = 1; cyc(); on_pin = 0; cyc();
        chk("R8", "on fall", flt_q, 6'b000000);
        pulse_ov();
        fet_on = 1; cyc(); fet_on = 0; cyc();
        chk("R8", "fet fall", flt_q, 6'b000000);

        cur_req = "R9";
        pulse_ov();
        uv_rst_lvl = 1; cyc(QUAL - 1); uv_rst_lvl = 0; cyc();
        chk("R9", "short run", flt_q, 6'b000001);
        uv_rst_lvl = 1; cyc(QUAL);
        chk("R9", "exact run", flt_q, 6'b000001);
        cyc();
        chk("R9", "qualified", flt_q, 6'b000000);
        ov_evt = 1; cyc(); ov_evt = 0;
        chk("R11", "set under hold", flt_q, 6'b000001);
        cyc();
        chk("R9", "hold repeats", flt_q, 6'b000000);
        uv_rst_lvl = 0; cyc();

        cur_req = "R10";
        pulse_ov();
        uvlo = 1; cyc();
        chk("R10", "lockout", flt_q, 6'b000000);
        cur_req = "R11";
        ov_evt = 1; cyc(); ov_evt = 0;
        chk("R11", "set beats lockout", flt_q, 6'b000001);
        cyc();
        chk("R10", "lockout again", flt_q, 6'b000000);
        uvlo = 0; cyc();

        cur_req = "R11";
        for (int c = 0; c < 600; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ov_lvl = lfsr[0]; uv_lvl = lfsr[1] & lfsr[5]; oc_lvl = lfsr[2] & lfsr[8];
            pbad_lvl = lfsr[3] & lfsr[4] & lfsr[6]; fshort_lvl = lfsr[7] & lfsr[9] & lfsr[11];
            ov_evt = lfsr[12]; uv_evt = lfsr[13] & lfsr[1]; oc_evt = lfsr[14] & lfsr[2];
            if (lfsr[4:0] == 5'd0) en_pin = ~en_pin;
            on_pin = lfsr[9] | lfsr[3];
            fet_on = lfsr[10] | lfsr[6] | lfsr[1];
            uv_rst_lvl = (c % 24) < 8;
            uvlo = (lfsr[15:11] == 5'd0);
            wr_en = (lfsr[6:4] == 3'd0);
            wr_data = lfsr[15:10];
            retry_en = lfsr[8:6];
            cyc();
        end
        cmp_on = 0;
        summary();
        $finish;
    end

endmodule